// File: doc/BRIEF.md
# Programmable First-Order Digital Phase-Locked Loop Core

This block is the core of a first-order all-digital phase-locked loop. A reference signal and a feedback signal enter two phase detectors. One is a registered exclusive-OR. The other is an edge-triggered set/clear flop. A select input picks which detector drives a loop-filter counter. The counter counts up or down. Its length is chosen at run time by a 4-bit code, from 3 to 17 stages, or the code switches the counter off. A short counter gives wide bandwidth and fast lock. A long counter gives narrow bandwidth and slow lock.

When the counter overflows it issues an advance request, and when it underflows it issues a retard request. An output pulse-stream stage then moves its square wave one enable interval earlier or later. That output drives an external divide-by-N counter, and the output of that counter returns as the feedback signal. Both internal clocks are clock enables derived from a single system clock. The loop filter steps on its enable, and the output stage steps on a separate enable.

Top module: `dpll_core`

## Requirements
- R1: `xor_out` equals the XOR of `ref_in` and `fb_in` as sampled at the previous rising clock edge.
- R2: A rising `ref_in` (a 0 in the previous sample, 1 now) sets `edge_out` at the next edge. A rising `fb_in` clears it. When both rise together, `edge_out` holds its value.
- R3: With `det_sel` = 0 the loop filter follows `xor_out`, and with `det_sel` = 1 it follows `edge_out`. On each `kclk_en` cycle it counts up when the followed value is 1 and down when it is 0.
- R4: A code c from 1 to 15 gives a counter of c+2 stages. Its range is 0 to 2^(c+2)-1 and its midpoint is 2^(c+1). Counting up from the top value raises an advance event, and counting down from 0 raises a retard event. Either event reloads the counter to the midpoint.
- R5: Code 0 holds the counter at 0 and raises no events, so `id_out` runs free.
- R6: A change of `mod_code` reloads the counter to the midpoint of the new length, or to 0 for code 0. That cycle performs no count and raises no event.
- R7: With no request pending, `id_out` toggles on every second `idclk_en` cycle. It never changes in a cycle without `idclk_en`.
- R8: A pending advance is used on the first `idclk_en` cycle on which no toggle is due. `id_out` toggles on that cycle, one enable early.
- R9: A pending retard is used on the first `idclk_en` cycle on which a toggle is due. That toggle is skipped, so the next one comes one enable late.
- R10: Only one request is held. An advance and a retard cancel each other. A second request of the same kind while one is pending is absorbed.
- R11: Synchronous active-low reset clears all state. `xor_out`, `edge_out` and `id_out` are 0 after reset.
- R12: Closed through a divide-by-64 counter, with `idclk_en` and `kclk_en` held high, the loop locks to a reference of period 264 cycles. Code 1 locks sooner than code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference signal |
| fb_in | input | 1 | Feedback from the external divider |
| det_sel | input | 1 | Detector select: 0 for XOR, 1 for edge |
| mod_code | input | 4 | Loop-filter length code (0 turns the counter off) |
| kclk_en | input | 1 | Loop-filter step enable |
| idclk_en | input | 1 | Output-stage step enable |
| xor_out | output | 1 | XOR detector result |
| edge_out | output | 1 | Edge detector result |
| id_out | output | 1 | Corrected pulse-stream output |

## Verification
The bench drives the loop filter to both ends of its range. A counter that wrapped instead of reloading to the midpoint would emit runs of events, and the toggle rate of `id_out` would drift from the reference model. It changes `mod_code` in the middle of a count, where a design that kept its old count would overrun the new range. It also makes both detector inputs rise in the same cycle, and it mixes random advance and retard events with sparse output enables. A design that applied an event twice, or failed to cancel opposing events, would shift `id_out` by one enable. Finally, it closes the loop at two lengths and checks that the lock time rises with length.

// File: rtl/dpll_pkg.sv
// Shared types for the digital PLL core.
package dpll_pkg;

    // Correction request held by the output stage
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_ADV  = 2'd1,
        ADJ_RET  = 2'd2
    } adj_t;

    // One-cycle events from the loop filter
    typedef struct packed {
        logic adv;
        logic ret;
    } lf_evt_t;

endpackage

// File: rtl/dpll_phase_det.sv
// Phase detectors: a registered XOR and an edge-triggered set/clear flop.
// Assumes ref_in and fb_in are already synchronous to clk.
module dpll_phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic xor_out,
    output logic edge_out
);
    logic ref_q, fb_q, xor_q, edge_q;
    logic ref_rise, fb_rise;

    assign ref_rise = ref_in & ~ref_q;
    assign fb_rise  = fb_in & ~fb_q;

    // Sample inputs, form XOR result, and set/clear edge result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= 1'b0;
            fb_q   <= 1'b0;
            xor_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
            fb_q  <= fb_in;
            xor_q <= ref_in ^ fb_in;
            if (ref_rise && !fb_rise)
                edge_q <= 1'b1;
            else if (fb_rise && !ref_rise)
                edge_q <= 1'b0;
        end
    end

    assign xor_out  = xor_q;
    assign edge_out = edge_q;

    // R1
    xor_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (xor_out == ($past(ref_in) ^ $past(fb_in))));
    // R2
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_in && !ref_q && !(fb_in && !fb_q)) |=> edge_out);
    // R2
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_in && !fb_q && !(ref_in && !ref_q)) |=> !edge_out);
endmodule

// File: rtl/dpll_loop_filter.sv
// Variable-length up/down loop-filter counter. Length is code+2 stages;
// code 0 turns it off. Overflow and underflow raise one-cycle events and
// reload the midpoint. A code change reloads the midpoint of the new length.
module dpll_loop_filter #(
    parameter int CODE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  up_dir,
    input  logic                  kclk_en,
    input  logic [CODE_W-1:0]     mod_code,
    output dpll_pkg::lf_evt_t     evt
);
    localparam int LEN_OFS = 2;
    localparam int CNT_W   = (1 << CODE_W) - 1 + LEN_OFS;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  top_val, mid_val, new_mid;
    logic              adv_q, ret_q;

    // All-ones value of the selected length
    function automatic logic [CNT_W-1:0] top_of(input logic [CODE_W-1:0] c);
        return {CNT_W{1'b1}} >> (CNT_W - LEN_OFS - int'(c));
    endfunction

    // Limits for the active length and for a newly requested one
    always_comb begin
        top_val = top_of(code_q);
        mid_val = (top_val >> 1) + 1'b1;
        new_mid = (mod_code == '0) ? '0 : ((top_of(mod_code) >> 1) + 1'b1);
    end

    // Count, detect the limits, and reload on events or code change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt_q  <= '0;
            adv_q  <= 1'b0;
            ret_q  <= 1'b0;
        end else begin
            adv_q <= 1'b0;
            ret_q <= 1'b0;
            if (mod_code != code_q) begin
                code_q <= mod_code;
                cnt_q  <= new_mid;
            end else if (kclk_en && code_q != '0) begin
                if (up_dir) begin
                    if (cnt_q == top_val) begin
                        adv_q <= 1'b1;
                        cnt_q <= mid_val;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        ret_q <= 1'b1;
                        cnt_q <= mid_val;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    assign evt.adv = adv_q;
    assign evt.ret = ret_q;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0) |-> (cnt_q <= top_val));
    // R4
    evt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_q || ret_q) |-> (cnt_q == mid_val));
    // R4
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_q && ret_q));
    // R5
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && mod_code == '0) |=> (!adv_q && !ret_q && cnt_q == '0));
    // R6
    code_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_code != code_q && mod_code != '0) |=> (cnt_q == mid_val && !adv_q && !ret_q));
endmodule

// File: rtl/dpll_incdec.sv
// Output pulse-stream stage. It toggles on every second enable. It holds
// one correction request, which moves one toggle a single enable earlier
// or later. Assumes adv and ret never arrive in the same cycle.
module dpll_incdec (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idclk_en,
    input  dpll_pkg::lf_evt_t   evt,
    output logic                id_out
);
    import dpll_pkg::*;

    adj_t pend_q, pend_base, pend_d;
    logic half_q, id_q;
    logic use_adv, use_ret;

    assign use_adv = idclk_en && (pend_q == ADJ_ADV) && !half_q;
    assign use_ret = idclk_en && (pend_q == ADJ_RET) && half_q;

    // Next request: consume, then merge a new event (opposites cancel)
    always_comb begin
        pend_base = (use_adv || use_ret) ? ADJ_NONE : pend_q;
        if (evt.adv)
            pend_d = (pend_base == ADJ_RET) ? ADJ_NONE : ADJ_ADV;
        else if (evt.ret)
            pend_d = (pend_base == ADJ_ADV) ? ADJ_NONE : ADJ_RET;
        else
            pend_d = pend_base;
    end

    // Advance the half-period phase and the output on each enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= ADJ_NONE;
            half_q <= 1'b0;
            id_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (idclk_en) begin
                if (use_adv) begin
                    id_q <= ~id_q;
                end else if (!use_ret) begin
                    half_q <= ~half_q;
                    if (half_q)
                        id_q <= ~id_q;
                end
            end
        end
    end

    assign id_out = id_q;

    // R7
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idclk_en |=> (id_out == $past(id_out)));
    // R8
    adv_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_adv |=> (id_out != $past(id_out)));
    // R9
    ret_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_ret |=> (id_out == $past(id_out)));
    // R10
    pend_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == ADJ_NONE || pend_q == ADJ_ADV || pend_q == ADJ_RET));
endmodule

// File: rtl/dpll_core.sv
// Top of the first-order digital PLL: detectors, selectable filter input,
// loop filter and output stage. The feedback divider is external.
module dpll_core #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic              det_sel,
    input  logic [CODE_W-1:0] mod_code,
    input  logic              kclk_en,
    input  logic              idclk_en,
    output logic              xor_out,
    output logic              edge_out,
    output logic              id_out
);
    dpll_pkg::lf_evt_t lf_evt;
    logic              up_dir;

    dpll_phase_det u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .fb_in    (fb_in),
        .xor_out  (xor_out),
        .edge_out (edge_out)
    );

    // Detector chosen to steer the loop filter
    assign up_dir = det_sel ? edge_out : xor_out;

    dpll_loop_filter #(.CODE_W(CODE_W)) u_lf (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_dir   (up_dir),
        .kclk_en  (kclk_en),
        .mod_code (mod_code),
        .evt      (lf_evt)
    );

    dpll_incdec u_id (
        .clk      (clk),
        .rst_n    (rst_n),
        .idclk_en (idclk_en),
        .evt      (lf_evt),
        .id_out   (id_out)
    );
endmodule

// File: tb/dpll_core_tb.sv
module dpll_core_tb;
    localparam int REF_P = 264;
    localparam int DIV_N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, det_sel = 1'b0;
    logic [3:0] mod_code = 4'd0;
    logic kclk_en = 1'b0, idclk_en = 1'b0;
    logic xor_out, edge_out, id_out;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R11";
    bit chk_on = 0;

    dpll_core u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .det_sel(det_sel), .mod_code(mod_code), .kclk_en(kclk_en),
        .idclk_en(idclk_en), .xor_out(xor_out), .edge_out(edge_out),
        .id_out(id_out)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    bit m_ref_q, m_fb_q, m_xor, m_edge, m_adv, m_ret, m_half, m_id;
    int m_code, m_cnt, m_pend;
    int t_top, t_mid, t_base;
    bit t_sel, t_ua, t_ur, t_na, t_nr, t_rr, t_fr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref_q = 0; m_fb_q = 0; m_xor = 0; m_edge = 0; m_adv = 0; m_ret = 0;
            m_half = 0; m_id = 0; m_code = 0; m_cnt = 0; m_pend = 0;
        end else begin
            t_sel = det_sel ? m_edge : m_xor;
            t_ua = idclk_en && m_pend == 1 && !m_half;
            t_ur = idclk_en && m_pend == 2 && m_half;
            if (idclk_en) begin
                if (t_ua) m_id = !m_id;
                else if (!t_ur) begin
                    if (m_half) m_id = !m_id;
                    m_half = !m_half;
                end
            end
            t_base = (t_ua || t_ur) ? 0 : m_pend;
            if (m_adv) m_pend = (t_base == 2) ? 0 : 1;
            else if (m_ret) m_pend = (t_base == 1) ? 0 : 2;
            else m_pend = t_base;
            t_na = 0; t_nr = 0;
            if (int'(mod_code) != m_code) begin
                m_code = int'(mod_code);
                m_cnt = (m_code == 0) ? 0 : (1 << (m_code + 1));
            end else if (kclk_en && m_code != 0) begin
                t_top = (1 << (m_code + 2)) - 1;
                t_mid = 1 << (m_code + 1);
                if (t_sel) begin
                    if (m_cnt == t_top) begin t_na = 1; m_cnt = t_mid; end
                    else m_cnt++;
                end else begin
                    if (m_cnt == 0) begin t_nr = 1; m_cnt = t_mid; end
                    else m_cnt--;
                end
            end
            m_adv = t_na; m_ret = t_nr;
            t_rr = ref_in && !m_ref_q;
            t_fr = fb_in && !m_fb_q;
            if (t_rr && !t_fr) m_edge = 1;
            else if (t_fr && !t_rr) m_edge = 0;
            m_xor = ref_in ^ fb_in;
            m_ref_q = ref_in; m_fb_q = fb_in;
        end
    end

    // Closed-loop environment: reference source, divider, lock detector
    bit loop_on = 0, id_prev = 0;
    int ref_cnt, div_cnt, cyc, last_fb, prev_ph, streak, n_ref, lock_at, ph;

    always @(negedge clk) begin
        if (chk_on) begin
            n_chk++;
            if (xor_out !== m_xor || edge_out !== m_edge || id_out !== m_id) begin
                n_fail++;
                $display("FAIL %s: xor/edge/id actual %b%b%b expected %b%b%b",
                         cur_req, xor_out, edge_out, id_out, m_xor, m_edge, m_id);
            end
        end
        if (loop_on) begin
            cyc++;
            ref_cnt = (ref_cnt + 1) % REF_P;
            ref_in = (ref_cnt < REF_P / 2);
            if (id_out && !id_prev) begin
                div_cnt = (div_cnt + 1) % DIV_N;
                if (div_cnt == DIV_N / 2) last_fb = cyc;
                fb_in = (div_cnt >= DIV_N / 2);
            end
            id_prev = id_out;
            if (ref_cnt == 0) begin
                ph = cyc - last_fb;
                if (ph - prev_ph <= 4 && prev_ph - ph <= 4) streak++;
                else streak = 0;
                prev_ph = ph;
                n_ref++;
                if (streak >= 6 && lock_at < 0) lock_at = n_ref;
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input bit ok);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_toggles(input int n, output int tg);
        logic last;
        tg = 0;
        last = id_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (id_out !== last) tg++;
            last = id_out;
        end
    endtask

    task automatic run_lock(input logic [3:0] code, output int lt);
        loop_on = 0;
        rst_n = 0; det_sel = 0; kclk_en = 1; idclk_en = 1;
        mod_code = code; ref_in = 0; fb_in = 0;
        step(3);
        ref_cnt = REF_P - 1; div_cnt = 0; cyc = 0; last_fb = 0; id_prev = 0;
        prev_ph = -1000; streak = 0; n_ref = 0; lock_at = -1;
        rst_n = 1;
        loop_on = 1;
        while (lock_at < 0 && n_ref < 60) @(negedge clk);
        loop_on = 0;
        lt = (lock_at < 0) ? 1000 : lock_at;
        check("R12 lock reached", lock_at, 1, lock_at >= 0);
    endtask

    int tg_a, tg_b, lt1, lt3;

    initial begin
        // R11: reset state
        step(3);
        check("R11 xor_out", int'(xor_out), 0, xor_out === 1'b0);
        check("R11 edge_out", int'(edge_out), 0, edge_out === 1'b0);
        check("R11 id_out", int'(id_out), 0, id_out === 1'b0);
        rst_n = 1;
        chk_on = 1;

        // R1: random detector inputs, counter off
        cur_req = "R1";
        for (int i = 0; i < 200; i++) begin
            ref_in = 1'($urandom); fb_in = 1'($urandom); step(1);
        end

        // R2: sparse edges, including simultaneous rises
        cur_req = "R2";
        det_sel = 1;
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 4 == 0) ref_in = !ref_in;
            if ($urandom % 4 == 0) fb_in = !fb_in;
            step(1);
        end
        ref_in = 0; fb_in = 0; step(1);
        ref_in = 1; fb_in = 1; step(2);

        // R5: counter off, free-running output
        cur_req = "R5";
        det_sel = 0; mod_code = 0; kclk_en = 1; idclk_en = 1;
        ref_in = 1; fb_in = 0;
        step(10);
        count_toggles(40, tg_a);
        check("R5 free-run toggles", tg_a, 20, tg_a == 20);

        // R3/R8: XOR high steady, short counter, advances speed up output
        cur_req = "R3";
        mod_code = 1;
        step(20);
        count_toggles(64, tg_a);
        check("R8 advance raises toggles", tg_a, 33, tg_a > 32);

        // R9: XOR low steady, retards slow output
        cur_req = "R9";
        ref_in = 0;
        step(20);
        count_toggles(64, tg_a);
        check("R9 retard lowers toggles", tg_a, 31, tg_a < 32);

        // R3: edge detector steering
        cur_req = "R3";
        det_sel = 1;
        for (int i = 0; i < 200; i++) begin
            ref_in = (i % 16) < 8; fb_in = ((i + 5) % 16) < 8; step(1);
        end

        // R4: lengths compared by advance rate
        cur_req = "R4";
        det_sel = 0; ref_in = 1; fb_in = 0; mod_code = 2;
        step(20);
        count_toggles(128, tg_a);
        mod_code = 4;
        step(20);
        count_toggles(128, tg_b);
        check("R4 shorter counter advances more", tg_a, tg_b + 1, tg_a > tg_b);

        // R6: code changes mid-count
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 9 == 0) mod_code = 4'($urandom % 6);
            ref_in = 1'($urandom); fb_in = 1'($urandom);
            kclk_en = 1'($urandom); step(1);
        end

        // R10: random events against sparse output enables
        cur_req = "R10";
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 50 == 0) mod_code = 4'(1 + $urandom % 2);
            ref_in = 1'($urandom); fb_in = 1'($urandom);
            det_sel = 1'($urandom); kclk_en = 1'($urandom);
            idclk_en = ($urandom % 3 == 0);
            step(1);
        end

        // R7: no enable, output frozen
        cur_req = "R7";
        idclk_en = 0;
        step(2);
        count_toggles(50, tg_a);
        check("R7 held without enable", tg_a, 0, tg_a == 0);
        idclk_en = 1;

        // R12: closed loop, lock time against length
        cur_req = "R12";
        run_lock(4'd1, lt1);
        run_lock(4'd3, lt3);
        check("R12 longer counter locks later", lt3, lt1 + 1, lt1 < lt3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule